// File: doc/BRIEF.md
# I2C Slave Transmitter Status Engine

This block is the read-side target of an I2C controller. It watches SCL and SDA through a synchroniser clocked by a much faster system clock. It finds START and STOP conditions and compares the incoming address byte with its own 7-bit address and a read direction bit. When it is addressed, it shifts out bytes that software hands over. Every meaningful bus event ends with an interrupt flag and an 8-bit status code, and SCL is held low until software has answered.

Software answers through three controls. The acknowledge-enable bit decides whether the address is acknowledged and whether the byte being loaded is the last one. A stop-request flag is used to leave an error state. A clear strobe drops the interrupt flag and lets the bus move on. An extra input marks that a master-side arbitration loss has just happened, so that an address hit in that situation is reported with its own code.

Top module: `i2c_stx_status`

## Requirements
- R1: After reset the status reads 0xF8, the interrupt flag and the stop-request flag are clear, and neither SCL nor SDA is pulled low.
- R2: While the interrupt flag is clear the status reads 0xF8. When the flag rises, the status holds one of 0xA8, 0xB0, 0xB8, 0xC0, 0xC8 or 0x00.
- R3: After START, an address byte whose upper seven bits (sent first) equal own_addr and whose last bit is 1 is acknowledged by SDA low in the ninth clock, provided ack_en is 1. The interrupt flag rises at the end of that ninth clock with status 0xA8, or 0xB0 if arb_lost was 1 when the eighth bit was sampled.
- R4: A different address, a last address bit of 0, or ack_en at 0 gets no acknowledge (SDA reads 1 in the ninth clock), no interrupt, and the status stays 0xF8.
- R5: Clearing the interrupt in an addressed wait state loads tx_byte, and its bits appear on SDA most-significant first, one per SCL clock.
- R6: After the eighth data bit the master's ninth-clock bit is sampled. 0 with ack_en at 1 when the byte was loaded gives 0xB8. 0 with ack_en at 0 at load gives 0xC8. 1 gives 0xC0.
- R7: Clearing the interrupt after 0xC0 or 0xC8 releases SDA and returns to the not-addressed state, so further master clocks read all-ones.
- R8: SCL is pulled low whenever the interrupt flag is set and for STRETCH_EXTRA clock cycles after it is cleared. It is then released.
- R9: A START or STOP seen while address bits 2 to 8 are being received, during the address acknowledge clock, during a data bit or during the data acknowledge clock raises the interrupt with status 0x00.
- R10: Setting stop_set and then pulsing int_clr while the interrupt is set clears the interrupt and the stop-request flag and releases SDA without creating a STOP. The block is then not addressed, and a later own-address read is reported with 0xA8.
- R11: The block changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (open drain) |
| sda_drive_low | output | 1 | 1 pulls SDA low (open drain) |
| own_addr | input | 7 | Own 7-bit slave address |
| ack_en | input | 1 | Assert-acknowledge control bit |
| arb_lost | input | 1 | Marks a preceding master arbitration loss |
| tx_byte | input | 8 | Next byte to transmit, taken on interrupt clear |
| stop_set | input | 1 | Pulse that sets the stop-request flag |
| int_clr | input | 1 | Pulse that clears the interrupt flag |
| irq | output | 1 | Serial interrupt flag |
| status | output | 8 | Status code |
| stop_pending | output | 1 | Stop-request flag |

## Verification
The bench builds the block with three synchroniser stages and STRETCH_EXTRA set to two. The longer detection delay still falls inside the modelled master's half bit period. The two-cycle tail after each clear can be counted at the SCL drive pin. An open-drain bus model with a bit-level master runs full read sessions that end in each of 0xB8, 0xC0 and 0xC8. It also runs the arbitration-loss address hit, three kinds of address rejection, and a STOP injected in the middle of a data byte and a repeated START injected in the middle of an address. Each injected error is followed by the recovery sequence and a fresh session.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WAIT,
        PH_TX,
        PH_TX_ACK,
        PH_ERR
    } phase_e;

    localparam logic [7:0] ST_NONE      = 8'hF8;
    localparam logic [7:0] ST_BUS_ERR   = 8'h00;
    localparam logic [7:0] ST_ADDR_HIT  = 8'hA8;
    localparam logic [7:0] ST_ARB_HIT   = 8'hB0;
    localparam logic [7:0] ST_DATA_ACK  = 8'hB8;
    localparam logic [7:0] ST_DATA_NACK = 8'hC0;
    localparam logic [7:0] ST_LAST_ACK  = 8'hC8;

    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 2);

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_is_ours(input logic [7:0] rx, input logic [6:0] own);
        return (rx[7:1] == own) && rx[0];
    endfunction

    function automatic logic [7:0] after_data_code(input logic master_nack, input logic last_byte);
        if (master_nack)
            return ST_DATA_NACK;
        else if (last_byte)
            return ST_LAST_ACK;
        else
            return ST_DATA_ACK;
    endfunction

    function automatic logic session_over(input logic [7:0] code);
        return (code == ST_DATA_NACK) || (code == ST_LAST_ACK);
    endfunction

endpackage

// File: rtl/stx_line_sync.sv
module stx_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst)
                chain <= '1;
            else
                chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/stx_bus_events.sv
module stx_bus_events
    import i2c_stx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s && !scl_prev;
        ev.scl_fall = !scl_s && scl_prev;
        ev.start    = scl_s && scl_prev && sda_prev && !sda_s;
        ev.stop     = scl_s && scl_prev && !sda_prev && sda_s;
    end
endmodule

// File: rtl/stx_tx_shift.sv
module stx_tx_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             advance,
    output logic             cur_bit,
    output logic             next_bit
);
    logic [WIDTH-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '1;
        else if (load)
            sh <= load_val;
        else if (advance)
            sh <= {sh[WIDTH-2:0], 1'b1};
    end

    assign cur_bit  = sh[WIDTH-1];
    assign next_bit = sh[WIDTH-2];
endmodule

// File: rtl/i2c_stx_status.sv
module i2c_stx_status
    import i2c_stx_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STRETCH_EXTRA = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic [6:0] own_addr,
    input  logic       ack_en,
    input  logic       arb_lost,
    input  logic [7:0] tx_byte,
    input  logic       stop_set,
    input  logic       int_clr,
    output logic       irq,
    output logic [7:0] status,
    output logic       stop_pending
);
    localparam int HOLD_W = (STRETCH_EXTRA < 2) ? 1 : $clog2(STRETCH_EXTRA + 1);

    logic [1:0] line_s;
    logic       scl_s;
    logic       sda_s;
    bus_ev_t    ev;

    stx_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    stx_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (ev)
    );

    phase_e               ph;
    logic [BIT_CNT_W-1:0] cnt;
    logic [7:0]           rx_sh;
    logic                 last_q;
    logic                 arb_q;
    logic                 nack_q;
    logic                 irq_q;
    logic [7:0]           code_q;
    logic                 sda_low_q;
    logic                 stop_q;
    logic [HOLD_W-1:0]    hold_cnt;

    logic tx_load;
    logic tx_adv;
    logic tx_cur;
    logic tx_next;
    logic clr_ok;
    logic frame_bad;
    logic [7:0] rx_next;

    assign clr_ok    = int_clr && irq_q;
    assign rx_next   = {rx_sh[6:0], ev.sda};
    assign frame_bad = (ev.start || ev.stop) &&
                       ((ph == PH_ADDR && cnt != '0) || ph == PH_ADDR_ACK ||
                        ph == PH_TX || ph == PH_TX_ACK);
    assign tx_load   = clr_ok && !stop_q && ph == PH_WAIT && !session_over(code_q);
    assign tx_adv    = !clr_ok && !frame_bad && ph == PH_TX && ev.scl_fall &&
                       cnt != BIT_CNT_W'(BYTE_BITS);

    stx_tx_shift #(.WIDTH(BYTE_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (tx_load),
        .load_val (tx_byte),
        .advance  (tx_adv),
        .cur_bit  (tx_cur),
        .next_bit (tx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            rx_sh     <= '0;
            last_q    <= 1'b0;
            arb_q     <= 1'b0;
            nack_q    <= 1'b0;
            irq_q     <= 1'b0;
            code_q    <= ST_NONE;
            sda_low_q <= 1'b0;
            stop_q    <= 1'b0;
            hold_cnt  <= '0;
        end else begin
            if (stop_set)
                stop_q <= 1'b1;
            if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;

            if (clr_ok) begin
                irq_q    <= 1'b0;
                hold_cnt <= HOLD_W'(STRETCH_EXTRA);
                if (stop_q) begin
                    ph        <= PH_IDLE;
                    stop_q    <= 1'b0;
                    sda_low_q <= 1'b0;
                end else if (ph == PH_WAIT) begin
                    if (session_over(code_q)) begin
                        ph        <= PH_IDLE;
                        sda_low_q <= 1'b0;
                    end else begin
                        ph        <= PH_TX;
                        cnt       <= '0;
                        last_q    <= !ack_en;
                        sda_low_q <= !tx_byte[7];
                    end
                end
            end else if (frame_bad) begin
                ph     <= PH_ERR;
                irq_q  <= 1'b1;
                code_q <= ST_BUS_ERR;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        if (ev.start) begin
                            ph  <= PH_ADDR;
                            cnt <= '0;
                        end
                    end
                    PH_ADDR: begin
                        if (ev.start) begin
                            cnt <= '0;
                        end else if (ev.stop) begin
                            ph <= PH_IDLE;
                        end else if (ev.scl_rise) begin
                            rx_sh <= rx_next;
                            cnt   <= cnt + 1'b1;
                            if (cnt == BIT_CNT_W'(BYTE_BITS - 1)) begin
                                if (addr_is_ours(rx_next, own_addr) && ack_en) begin
                                    ph    <= PH_ADDR_ACK;
                                    arb_q <= arb_lost;
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == BIT_CNT_W'(BYTE_BITS)) begin
                                sda_low_q <= 1'b1;
                            end else begin
                                sda_low_q <= 1'b0;
                                irq_q     <= 1'b1;
                                code_q    <= arb_q ? ST_ARB_HIT : ST_ADDR_HIT;
                                ph        <= PH_WAIT;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == BIT_CNT_W'(BYTE_BITS)) begin
                                sda_low_q <= 1'b0;
                                ph        <= PH_TX_ACK;
                            end else begin
                                sda_low_q <= !tx_next;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.scl_rise) begin
                            nack_q <= ev.sda;
                            cnt    <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            irq_q  <= 1'b1;
                            code_q <= after_data_code(nack_q, last_q);
                            ph     <= PH_WAIT;
                        end
                    end
                    PH_ERR: begin
                        if (!ev.scl)
                            sda_low_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_drive_low = irq_q || (hold_cnt != '0);
    assign sda_drive_low = sda_low_q;
    assign irq           = irq_q;
    assign status        = irq_q ? code_q : ST_NONE;
    assign stop_pending  = stop_q;

    logic unused_ok;
    assign unused_ok = tx_cur;
endmodule

// File: rtl/i2c_stx_status_chk.sv
module i2c_stx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic [7:0] status,
    input logic       sda_low,
    input logic       scl_s,
    input logic       int_clr,
    input logic       stop_pending
);
    // R2: a newly raised interrupt always carries a defined code
    a_r2_defined_code: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status == 8'hA8 || status == 8'hB0 || status == 8'hB8 ||
                        status == 8'hC0 || status == 8'hC8 || status == 8'h00));

    // R7: ending a session after C0/C8 leaves SDA released
    a_r7_session_release: assert property (@(posedge clk) disable iff (rst)
        ($past(irq) && !irq && ($past(status) == 8'hC0 || $past(status) == 8'hC8))
        |-> !sda_low);

    // R8: while the flag is set the synchronised clock cannot rise
    a_r8_stretch_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(irq)) |-> !(scl_s && !$past(scl_s)));

    // R10: recovery clears flag and request in one step
    a_r10_recover: assert property (@(posedge clk) disable iff (rst)
        (int_clr && irq && stop_pending) |=> (!irq && !stop_pending && status == 8'hF8));

    // R11: SDA drive moves only while synchronised SCL was low
    a_r11_sda_when_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> !$past(scl_s));
endmodule

bind i2c_stx_status i2c_stx_status_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq          (irq),
    .status       (status),
    .sda_low      (sda_drive_low),
    .scl_s        (scl_s),
    .int_clr      (int_clr),
    .stop_pending (stop_pending)
);

// File: tb/i2c_stx_status_bench.sv
module i2c_stx_status_bench;
    localparam int HP      = 12;
    localparam int STRETCH = 2;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       m_scl = 1'b0;
    logic       m_sda = 1'b0;
    logic       dut_scl, dut_sda;
    logic       scl_line, sda_line;
    logic       ack_en = 1'b1;
    logic       arb_lost = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       stop_set = 1'b0;
    logic       int_clr = 1'b0;
    logic       irq, stop_pending;
    logic [7:0] status;

    assign scl_line = !(m_scl || dut_scl);
    assign sda_line = !(m_sda || dut_sda);

    i2c_stx_status #(.SYNC_STAGES(3), .STRETCH_EXTRA(STRETCH)) u_i2c_stx_status (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(dut_scl), .sda_drive_low(dut_sda),
        .own_addr(OWN), .ack_en(ack_en), .arb_lost(arb_lost),
        .tx_byte(tx_byte), .stop_set(stop_set), .int_clr(int_clr),
        .irq(irq), .status(status), .stop_pending(stop_pending)
    );

    int checks = 0;
    int errors = 0;
    int sda_viol = 0;

    typedef struct {
        logic [7:0] code;
        logic [7:0] nxt;
        logic       ack;
        logic       stop;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic expect_irq(input logic [7:0] code, input logic [7:0] nxt,
                              input logic ack, input logic stop, input string tag);
        exp_t e;
        e.code = code; e.nxt = nxt; e.ack = ack; e.stop = stop; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor / software responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && irq === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected interrupt", {24'h0, status}, 32'h0);
                    int_clr = 1'b1; @(negedge clk); int_clr = 1'b0;
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(status == e.code, e.tag, "status code", {24'h0, status}, {24'h0, e.code});
                    repeat (4) @(negedge clk);
                    chk(dut_scl == 1'b1, "R8", "SCL held during interrupt", dut_scl, 1);
                    tx_byte = e.nxt;
                    ack_en  = e.ack;
                    if (e.stop) begin
                        stop_set = 1'b1; @(negedge clk); stop_set = 1'b0;
                        chk(stop_pending == 1'b1, "R10", "stop request latched", stop_pending, 1);
                    end
                    int_clr = 1'b1; @(negedge clk); int_clr = 1'b0;
                    for (int k = 0; k < STRETCH; k++) begin
                        chk(dut_scl == 1'b1, "R8", "SCL tail after clear", dut_scl, 1);
                        @(negedge clk);
                    end
                    chk(dut_scl == 1'b0, "R8", "SCL released after tail", dut_scl, 0);
                    chk(status == 8'hF8, "R2", "status after clear", {24'h0, status}, 32'hF8);
                    if (e.stop) begin
                        chk(stop_pending == 1'b0, "R10", "stop request cleared", stop_pending, 0);
                        chk(dut_sda == 1'b0, "R10", "SDA released", dut_sda, 0);
                    end
                end
            end
        end
    end

    // R11 monitor: SDA drive must not move while SCL is high
    initial begin
        forever begin
            @(dut_sda);
            if (!rst && scl_line === 1'b1) sda_viol++;
        end
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic m_start();
        @(negedge clk); m_sda = 1'b1; hp(); m_scl = 1'b1;
    endtask

    task automatic m_rstart();
        @(negedge clk); m_sda = 1'b0; hp(); m_scl = 1'b0;
        wait (scl_line === 1'b1); hp(); m_sda = 1'b1; hp(); m_scl = 1'b1;
    endtask

    task automatic m_wbit(input logic b);
        @(negedge clk); m_sda = !b; hp(); m_scl = 1'b0;
        wait (scl_line === 1'b1); hp(); m_scl = 1'b1;
    endtask

    task automatic m_rbit(output logic b);
        @(negedge clk); m_sda = 1'b0; hp(); m_scl = 1'b0;
        wait (scl_line === 1'b1);
        repeat (HP / 2) @(negedge clk);
        b = sda_line;
        repeat (HP - HP / 2) @(negedge clk);
        m_scl = 1'b1;
    endtask

    task automatic m_stop();
        @(negedge clk); m_sda = 1'b1; hp(); m_scl = 1'b0;
        wait (scl_line === 1'b1); hp(); m_sda = 1'b0; hp();
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic ack_bit);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(ack_bit);
    endtask

    task automatic m_rbyte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            m_rbit(b);
            v[i] = b;
        end
        m_wbit(nack);
    endtask

    task automatic settle();
        wait (irq === 1'b0 && scl_line === 1'b1);
        hp(); hp();
    endtask

    task automatic finish_run();
        chk(sda_viol == 0, "R11", "SDA changes with SCL high", sda_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic       a;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 8'hF8, "R1", "reset status", {24'h0, status}, 32'hF8);
        chk(irq == 1'b0, "R1", "reset irq", irq, 0);
        chk(stop_pending == 1'b0, "R1", "reset stop flag", stop_pending, 0);
        chk(dut_scl == 1'b0 && dut_sda == 1'b0, "R1", "lines released", {dut_scl, dut_sda}, 0);
        hp();

        // session 1: A8, B8, C8 then all-ones
        expect_irq(8'hA8, 8'h5A, 1'b1, 1'b0, "R3");
        expect_irq(8'hB8, 8'hC3, 1'b0, 1'b0, "R6");
        expect_irq(8'hC8, 8'h00, 1'b1, 1'b0, "R6");
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk(a == 1'b0, "R3", "address acknowledged", a, 0);
        m_rbyte(d, 1'b0);
        chk(d == 8'h5A, "R5", "first data byte", d, 8'h5A);
        m_rbyte(d, 1'b0);
        chk(d == 8'hC3, "R5", "second data byte", d, 8'hC3);
        m_rbyte(d, 1'b1);
        chk(d == 8'hFF, "R7", "after last byte", d, 8'hFF);
        m_stop();
        settle();
        chk(status == 8'hF8, "R2", "idle status", {24'h0, status}, 32'hF8);

        // session 2: arbitration-loss hit, master NACK, then all-ones
        arb_lost = 1'b1;
        expect_irq(8'hB0, 8'h81, 1'b1, 1'b0, "R3");
        expect_irq(8'hC0, 8'h00, 1'b1, 1'b0, "R6");
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        arb_lost = 1'b0;
        chk(a == 1'b0, "R3", "address acknowledged after arbitration loss", a, 0);
        m_rbyte(d, 1'b1);
        chk(d == 8'h81, "R5", "byte before NACK", d, 8'h81);
        m_rbyte(d, 1'b1);
        chk(d == 8'hFF, "R7", "after NACK", d, 8'hFF);
        m_stop();
        settle();

        // rejections
        m_start();
        m_wbyte({OWN ^ 7'h01, 1'b1}, a);
        chk(a == 1'b1, "R4", "other address not acknowledged", a, 1);
        m_stop();
        chk(irq == 1'b0 && status == 8'hF8, "R4", "no event for other address", {23'h0, irq, status}, 32'hF8);
        m_start();
        m_wbyte({OWN, 1'b0}, a);
        chk(a == 1'b1, "R4", "write direction not acknowledged", a, 1);
        m_stop();
        ack_en = 1'b0;
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk(a == 1'b1, "R4", "acknowledge disabled", a, 1);
        m_stop();
        chk(irq == 1'b0 && status == 8'hF8, "R4", "no event when disabled", {23'h0, irq, status}, 32'hF8);
        ack_en = 1'b1;
        hp();

        // STOP in the middle of a data byte
        expect_irq(8'hA8, 8'hF0, 1'b1, 1'b0, "R3");
        expect_irq(8'h00, 8'h00, 1'b1, 1'b1, "R9");
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        for (int i = 0; i < 3; i++) begin
            m_rbit(a);
            chk(a == 1'b1, "R5", "leading data bit", a, 1);
        end
        m_stop();
        settle();

        // repeated START in the middle of an address
        expect_irq(8'h00, 8'h00, 1'b1, 1'b1, "R9");
        m_start();
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        m_rstart();
        m_stop();
        settle();

        // fresh session after recovery
        expect_irq(8'hA8, 8'h3C, 1'b0, 1'b0, "R10");
        expect_irq(8'hC8, 8'h00, 1'b1, 1'b0, "R6");
        m_start();
        m_wbyte({OWN, 1'b1}, a);
        chk(a == 1'b0, "R10", "addressed again after recovery", a, 0);
        m_rbyte(d, 1'b0);
        chk(d == 8'h3C, "R5", "byte after recovery", d, 8'h3C);
        m_stop();
        settle();

        chk(exp_q.size() == 0, "R2", "all expected events seen", exp_q.size(), 0);
        finish_run();
    end
endmodule